// File: doc/BRIEF.md
# IP header exception classifier

This block sits behind a receive port and inspects the network-layer header of each incoming frame. At frame start it learns where the IP header begins and how many bytes the frame holds. It then accepts the frame's bytes one per handshake and works out a numbered exception code plus a set of protocol flags from the header alone. Only the bytes up to the end of the IP header are consumed. Once the header is complete, or the frame runs out first, the block stops accepting bytes and raises a one-cycle done pulse.

The header checksum is added up as bytes stream past, so no header storage is needed. All exception conditions are resolved at one point, the final header byte, where the lowest-numbered failing condition wins. A frame flagged with a link-level receive error is not examined at all. The results stay on the outputs until the next frame start.

Top module: `ip_hdr_classifier`

## Requirements
- R1: After reset every output is 0 and in_ready is low. in_ready goes high the cycle after an accepted sof and drops after the final header byte or the final frame byte is taken. done pulses for one cycle, in the cycle that follows that byte. The results then hold until the next sof.
- R2: If the upper nibble of the first IP byte (byte 0 from the IP offset) is neither 4 nor 6, the block finishes on that byte with code 1.
- R3: The block gives code 3 in three cases: the frame ends before the header is complete, the IPv4 header length nibble (lower nibble of byte 0) is below 5, or frame_len is not larger than ip_off. The IPv4 header is 4 times the nibble in bytes and the IPv6 header is 40 bytes.
- R4: For IPv4, the ones'-complement sum of the header's 16-bit big-endian words, checksum word included, must equal 0xFFFF. Otherwise the code is 2. IPv6 never yields code 2.
- R5: Code 4 is given when frame_len minus ip_off is less than the declared length. For IPv4 that is the total length in bytes 2-3. For IPv6 it is 40 plus the payload length in bytes 4-5. Extra pad bytes give no exception.
- R6: A zero IPv4 TTL (byte 8) or a zero IPv6 hop limit (byte 7) gives code 5.
- R7: An IPv4 header length nibble above 5 (options present) gives code 6.
- R8: When several of codes 2, 4, 5 and 6 hold together, the smallest is reported. Code 1 takes precedence over code 3 on the first byte. The code never exceeds 6.
- R9: If rx_err is set with sof, no byte is accepted and done pulses the next cycle with code 0 and all flags clear.
- R10: The protocol byte (IPv4 byte 9, IPv6 next header byte 6) sets is_tcp_udp for 6 or 17, needs_decrypt for 50 or 51, and needs_decomp for 108.
- R11: is_frag is set for IPv4 when the more-fragments bit (bit 5 of byte 6) is 1 or the 13-bit fragment offset (byte 6 bits 4:0 and byte 7) is nonzero. For IPv6 it is set when the next header is 44. is_v6 marks a version-6 header.
- R12: ip_exc is 1 exactly when the code is nonzero. Codes 1 and 3 leave is_v6, is_frag, is_tcp_udp, needs_decrypt and needs_decomp at 0. Codes 0, 2, 4, 5 and 6 report them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sof | input | 1 | Frame start, one cycle; samples ip_off, frame_len, rx_err |
| ip_off | input | OFF_W | Byte index of the first IP byte within the frame |
| frame_len | input | LEN_W | Total frame byte count |
| rx_err | input | 1 | Link-level receive error for this frame |
| in_valid | input | 1 | Byte on in_data is valid |
| in_data | input | 8 | Frame byte, in frame order from byte 0 |
| in_ready | output | 1 | Block accepts a byte this cycle |
| done | output | 1 | One-cycle pulse: results valid |
| ip_exc | output | 1 | An exception was found |
| exc_code | output | 8 | Exception code, 0 when none |
| is_v6 | output | 1 | Header is IPv6 |
| is_frag | output | 1 | Packet is a fragment |
| is_tcp_udp | output | 1 | Transport is TCP or UDP |
| needs_decrypt | output | 1 | ESP or AH payload |
| needs_decomp | output | 1 | IP compression payload |

## Verification
The bench goes after the priority cases: a zero TTL combined with a bad checksum, and a zero TTL combined with a short frame. A design that checks conditions in the wrong order would report 5 in both cases instead of 2 and 4. Frames whose length equals the declared length exactly, or exceeds it with pad, catch an off-by-one or an inverted length compare. Such a design would raise code 4 on good traffic. Other frames end inside the header, in IPv4 and in IPv6, or carry a header-length nibble of 4. These show whether the block stops early with code 3 and clear flags, rather than hanging for bytes that never come or leaking half-captured flags. Input bubbles and a zero IP offset test that the byte position and the checksum pairing do not slip.

// File: rtl/ip_hdr_classifier.sv
module ip_hdr_classifier #(
  parameter int OFF_W = 8,
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic [OFF_W-1:0] ip_off,
  input  logic [LEN_W-1:0] frame_len,
  input  logic             rx_err,
  input  logic             in_valid,
  input  logic [7:0]       in_data,
  output logic             in_ready,
  output logic             done,
  output logic             ip_exc,
  output logic [7:0]       exc_code,
  output logic             is_v6,
  output logic             is_frag,
  output logic             is_tcp_udp,
  output logic             needs_decrypt,
  output logic             needs_decomp
);
  localparam int AW = LEN_W + 1;

  logic             run;
  logic [LEN_W-1:0] pos, flen;
  logic [OFF_W-1:0] off;
  logic             v6, frag4;
  logic [3:0]       ihl;
  logic [5:0]       hl;
  logic [7:0]       len_hi, ttl, proto, hi;
  logic [LEN_W-1:0] dlen;
  logic [15:0]      csum;

  logic [LEN_W-1:0] rel;
  logic [5:0]       idx;
  logic             beat, in_hdr, b0, ver_bad, ihl_bad, last_hdr, last_frame, fin;
  logic [16:0]      add;
  logic [15:0]      sum_nx;
  logic [AW-1:0]    need, avail;
  logic [7:0]       code_hdr, fcode;

  assign in_ready   = run;
  assign beat       = run & in_valid;
  assign rel        = pos - LEN_W'(off);
  assign in_hdr     = (pos >= LEN_W'(off)) && (rel < LEN_W'(64));
  assign idx        = rel[5:0];
  assign b0         = in_hdr && idx == 6'd0;
  assign ver_bad    = b0 && in_data[7:4] != 4'd4 && in_data[7:4] != 4'd6;
  assign ihl_bad    = b0 && in_data[7:4] == 4'd4 && in_data[3:0] < 4'd5;
  assign last_hdr   = in_hdr && !b0 && idx == hl - 6'd1;
  assign last_frame = pos == flen - LEN_W'(1);
  assign fin        = beat && (ver_bad || ihl_bad || last_hdr || last_frame);

  assign add    = {1'b0, csum} + {1'b0, hi, in_data};
  assign sum_nx = add[15:0] + {15'd0, add[16]};

  assign avail = AW'(flen) - AW'(off);
  assign need  = AW'(dlen) + (v6 ? AW'(40) : AW'(0));

  always_comb begin
    if (!v6 && sum_nx != 16'hFFFF)  code_hdr = 8'd2;
    else if (avail < need)          code_hdr = 8'd4;
    else if (ttl == 8'd0)           code_hdr = 8'd5;
    else if (!v6 && ihl > 4'd5)     code_hdr = 8'd6;
    else                            code_hdr = 8'd0;
    if (ver_bad)       fcode = 8'd1;
    else if (ihl_bad)  fcode = 8'd3;
    else if (last_hdr) fcode = code_hdr;
    else               fcode = 8'd3;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0; pos <= '0; flen <= '0; off <= '0;
      v6 <= 1'b0; frag4 <= 1'b0; ihl <= '0; hl <= '0;
      len_hi <= '0; ttl <= '0; proto <= '0; hi <= '0; dlen <= '0; csum <= '0;
      done <= 1'b0; ip_exc <= 1'b0; exc_code <= '0;
      is_v6 <= 1'b0; is_frag <= 1'b0; is_tcp_udp <= 1'b0;
      needs_decrypt <= 1'b0; needs_decomp <= 1'b0;
    end else begin
      done <= 1'b0;
      if (sof) begin
        pos <= '0; off <= ip_off; flen <= frame_len;
        csum <= '0; frag4 <= 1'b0; v6 <= 1'b0; run <= 1'b0;
        ip_exc <= 1'b0; exc_code <= '0;
        is_v6 <= 1'b0; is_frag <= 1'b0; is_tcp_udp <= 1'b0;
        needs_decrypt <= 1'b0; needs_decomp <= 1'b0;
        if (rx_err) begin
          done <= 1'b1;
        end else if (frame_len <= LEN_W'(ip_off)) begin
          done <= 1'b1; ip_exc <= 1'b1; exc_code <= 8'd3;
        end else begin
          run <= 1'b1;
        end
      end else if (beat) begin
        pos <= pos + LEN_W'(1);
        if (in_hdr) begin
          if (idx[0]) csum <= sum_nx;
          else        hi <= in_data;
          if (b0) begin
            v6  <= in_data[7:4] == 4'd6;
            ihl <= in_data[3:0];
            hl  <= (in_data[7:4] == 4'd6) ? 6'd40 : {in_data[3:0], 2'b00};
          end
          if (!v6) begin
            if (idx == 6'd2) len_hi <= in_data;
            if (idx == 6'd3) dlen <= LEN_W'({len_hi, in_data});
            if (idx == 6'd6) frag4 <= in_data[5] | (|in_data[4:0]);
            if (idx == 6'd7) frag4 <= frag4 | (|in_data);
            if (idx == 6'd8) ttl <= in_data;
            if (idx == 6'd9) proto <= in_data;
          end else begin
            if (idx == 6'd4) len_hi <= in_data;
            if (idx == 6'd5) dlen <= LEN_W'({len_hi, in_data});
            if (idx == 6'd6) proto <= in_data;
            if (idx == 6'd7) ttl <= in_data;
          end
        end
        if (fin) begin
          run <= 1'b0; done <= 1'b1;
          exc_code <= fcode; ip_exc <= fcode != 8'd0;
          if (last_hdr && !ver_bad && !ihl_bad) begin
            is_v6         <= v6;
            is_frag       <= v6 ? (proto == 8'd44) : frag4;
            is_tcp_udp    <= proto == 8'd6 || proto == 8'd17;
            needs_decrypt <= proto == 8'd50 || proto == 8'd51;
            needs_decomp  <= proto == 8'd108;
          end
        end
      end
    end
  end
endmodule

// File: rtl/ip_hdr_classifier_chk.sv
module ip_hdr_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sof,
  input logic       rx_err,
  input logic       in_ready,
  input logic       done,
  input logic       ip_exc,
  input logic [7:0] exc_code,
  input logic       is_v6,
  input logic       is_frag,
  input logic       is_tcp_udp,
  input logic       needs_decrypt,
  input logic       needs_decomp
);
  // R1
  ready_low_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && !in_ready) |=> $stable({ip_exc, exc_code, is_v6, is_frag, is_tcp_udp,
                                     needs_decrypt, needs_decomp}));

  // R9
  rx_err_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sof && rx_err) |=> (done && exc_code == 8'd0 && !ip_exc && !in_ready));

  // R12
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (exc_code == 8'd1 || exc_code == 8'd3)) |->
      !(is_v6 | is_frag | is_tcp_udp | needs_decrypt | needs_decomp));

  // R4
  v6_no_csum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_v6) |-> (exc_code != 8'd2 && exc_code != 8'd6));

  // R8
  code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_code <= 8'd6);
endmodule

bind ip_hdr_classifier ip_hdr_classifier_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sof(sof), .rx_err(rx_err), .in_ready(in_ready),
  .done(done), .ip_exc(ip_exc), .exc_code(exc_code), .is_v6(is_v6),
  .is_frag(is_frag), .is_tcp_udp(is_tcp_udp), .needs_decrypt(needs_decrypt),
  .needs_decomp(needs_decomp)
);

// File: tb/ip_hdr_classifier_tb.sv
module ip_hdr_classifier_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        sof = 0, rx_err = 0, in_valid = 0;
  logic [7:0]  ip_off = 0, in_data = 0;
  logic [15:0] frame_len = 0;
  logic        in_ready, done, ip_exc, is_v6, is_frag, is_tcp_udp, needs_decrypt, needs_decomp;
  logic [7:0]  exc_code;

  ip_hdr_classifier u_dut (
    .clk(clk), .rst_n(rst_n), .sof(sof), .ip_off(ip_off), .frame_len(frame_len),
    .rx_err(rx_err), .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .done(done), .ip_exc(ip_exc), .exc_code(exc_code), .is_v6(is_v6),
    .is_frag(is_frag), .is_tcp_udp(is_tcp_udp), .needs_decrypt(needs_decrypt),
    .needs_decomp(needs_decomp)
  );

  typedef struct packed {
    logic [7:0] code;
    logic exc, v6, frag, tu, sec, cmp;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];
  int    n_cmp = 0, n_bad = 0;
  bit    finished = 0;
  logic [7:0] fb [0:255];

  function automatic res_t got_now();
    res_t g;
    g.code = exc_code; g.exc = ip_exc; g.v6 = is_v6; g.frag = is_frag;
    g.tu = is_tcp_udp; g.sec = needs_decrypt; g.cmp = needs_decomp;
    return g;
  endfunction

  task automatic compare(string rq, res_t g, res_t e);
    n_cmp++;
    if (g !== e) begin
      n_bad++;
      $display("FAIL %s: got code=%0d exc=%b v6=%b frag=%b tu=%b sec=%b cmp=%b, expected code=%0d exc=%b v6=%b frag=%b tu=%b sec=%b cmp=%b",
               rq, g.code, g.exc, g.v6, g.frag, g.tu, g.sec, g.cmp,
               e.code, e.exc, e.v6, e.frag, e.tu, e.sec, e.cmp);
    end
  endtask

  // monitor: pops one expected result per done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R1: unexpected done, got 1 expected 0");
      end else begin
        compare(tag_q.pop_front(), got_now(), exp_q.pop_front());
      end
    end
  end

  function automatic int hsum(int off, int n);
    int s = 0;
    for (int k = 0; k < n; k += 2) begin
      s = s + {fb[off+k], fb[off+k+1]};
      s = (s & 32'hFFFF) + (s >> 16);
    end
    return s;
  endfunction

  task automatic fill_l2();
    for (int k = 0; k < 256; k++) fb[k] = 8'(k * 7 + 3);
  endtask

  task automatic put_v4(int off, int ihl, int tot, bit mf, int foff, int ttl, int pr, bit bad);
    int s;
    fill_l2();
    fb[off] = {4'd4, 4'(ihl)};
    fb[off+1] = 8'h00; fb[off+2] = 8'(tot >> 8); fb[off+3] = 8'(tot);
    fb[off+4] = 8'h12; fb[off+5] = 8'h34;
    fb[off+6] = {2'b00, mf, 5'(foff >> 8)}; fb[off+7] = 8'(foff);
    fb[off+8] = 8'(ttl); fb[off+9] = 8'(pr); fb[off+10] = 0; fb[off+11] = 0;
    for (int k = 12; k < 20; k++) fb[off+k] = 8'(k * 13 + 1);
    for (int k = 20; k < ihl * 4; k++) fb[off+k] = 8'h01;
    if (ihl >= 5) begin
      s = hsum(off, ihl * 4);
      fb[off+10] = ~8'(s >> 8); fb[off+11] = ~8'(s);
      if (bad) fb[off+11] = fb[off+11] ^ 8'h04;
    end
  endtask

  task automatic put_v6(int off, int plen, int nh, int hop);
    fill_l2();
    fb[off] = 8'h60; fb[off+1] = 8'h00; fb[off+2] = 8'h00; fb[off+3] = 8'h00;
    fb[off+4] = 8'(plen >> 8); fb[off+5] = 8'(plen); fb[off+6] = 8'(nh); fb[off+7] = 8'(hop);
    for (int k = 8; k < 40; k++) fb[off+k] = 8'(k * 5 + 2);
  endtask

  // reference model built from the requirements
  function automatic res_t model(int off, int flen, bit rxe);
    res_t e = '0;
    int ver, ihl, hl, pr, ttl, dlen, need;
    bit v6;
    if (rxe) return e;
    if (flen <= off) begin e.code = 3; e.exc = 1; return e; end
    ver = fb[off][7:4]; ihl = fb[off][3:0];
    if (ver != 4 && ver != 6) begin e.code = 1; e.exc = 1; return e; end
    if (ver == 4 && ihl < 5) begin e.code = 3; e.exc = 1; return e; end
    v6 = (ver == 6);
    hl = v6 ? 40 : ihl * 4;
    if (flen - off < hl) begin e.code = 3; e.exc = 1; return e; end
    pr   = v6 ? fb[off+6] : fb[off+9];
    ttl  = v6 ? fb[off+7] : fb[off+8];
    dlen = v6 ? {fb[off+4], fb[off+5]} : {fb[off+2], fb[off+3]};
    need = v6 ? dlen + 40 : dlen;
    if (!v6 && hsum(off, hl) != 16'hFFFF) e.code = 2;
    else if (flen - off < need)          e.code = 4;
    else if (ttl == 0)                   e.code = 5;
    else if (!v6 && ihl > 5)             e.code = 6;
    e.exc = e.code != 0;
    e.v6  = v6;
    e.frag = v6 ? (pr == 44) : (fb[off+6][5] || fb[off+6][4:0] != 0 || fb[off+7] != 0);
    e.tu  = (pr == 6 || pr == 17);
    e.sec = (pr == 50 || pr == 51);
    e.cmp = (pr == 108);
    return e;
  endfunction

  task automatic run_frame(string rq, int off, int flen, bit rxe, bit gaps);
    res_t e;
    int   i;
    bit   skip;
    e = model(off, flen, rxe);
    exp_q.push_back(e); tag_q.push_back(rq);
    @(negedge clk);
    sof = 1; ip_off = 8'(off); frame_len = 16'(flen); rx_err = rxe;
    @(negedge clk);
    sof = 0; rx_err = 0;
    i = 0; skip = 0;
    while (i < flen) begin
      if (!in_ready) break;
      if (gaps && (i % 3 == 1) && !skip) begin
        in_valid = 0; skip = 1;
        @(negedge clk);
        continue;
      end
      skip = 0;
      in_valid = 1; in_data = fb[i];
      @(negedge clk);
      i++;
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    n_cmp++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R1 (%s): done missing, got %0d pending expected 0", rq, exp_q.size());
      exp_q.delete(); tag_q.delete();
    end
    // R1 results hold after done until next sof
    compare({"R1 hold ", rq}, got_now(), e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    compare("R1 reset", got_now(), '0);
    n_cmp++;
    if (in_ready !== 1'b0 || done !== 1'b0) begin
      n_bad++; $display("FAIL R1 reset: got ready=%b done=%b expected 0 0", in_ready, done);
    end

    put_v4(14, 5, 40, 0, 0, 64, 6, 0);     run_frame("R10 tcp v4", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0);     run_frame("R10 gaps", 14, 60, 0, 1);
    put_v4(14, 5, 40, 0, 0, 64, 6, 1);     run_frame("R4 bad csum", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0); fb[14] = 8'h55;
                                           run_frame("R2 version 5", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0); fb[14] = 8'h05;
                                           run_frame("R2 R8 version 0 last byte", 14, 15, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0);     run_frame("R3 truncated v4", 14, 26, 0, 0);
    put_v4(14, 4, 40, 0, 0, 64, 6, 0);     run_frame("R3 ihl 4", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0);     run_frame("R3 no ip bytes", 14, 10, 0, 0);
    put_v4(14, 5, 100, 0, 0, 64, 17, 0);   run_frame("R5 short frame", 14, 60, 0, 0);
    put_v4(14, 5, 30, 0, 0, 64, 17, 0);    run_frame("R5 pad allowed", 14, 200, 0, 0);
    put_v4(0, 5, 20, 0, 0, 64, 17, 0);     run_frame("R5 exact len off 0", 0, 20, 0, 1);
    put_v4(14, 5, 40, 0, 0, 0, 6, 0);      run_frame("R6 ttl zero", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 0, 0, 6, 1);      run_frame("R8 ttl0 and csum", 14, 60, 0, 0);
    put_v4(14, 5, 90, 0, 0, 0, 6, 0);      run_frame("R8 ttl0 and short", 14, 60, 0, 0);
    put_v4(14, 6, 40, 0, 0, 64, 50, 0);    run_frame("R7 options esp", 14, 60, 0, 0);
    put_v4(14, 5, 40, 1, 0, 64, 51, 0);    run_frame("R11 mf ah", 14, 60, 0, 0);
    put_v4(14, 5, 40, 0, 300, 64, 108, 0); run_frame("R11 offset comp", 14, 60, 0, 0);
    put_v6(18, 20, 17, 64);                run_frame("R11 v6 udp", 18, 78, 0, 0);
    put_v6(18, 20, 17, 0);                 run_frame("R6 hop zero", 18, 78, 0, 0);
    put_v6(18, 20, 44, 8);                 run_frame("R11 v6 frag", 18, 78, 0, 1);
    put_v6(18, 20, 50, 8);                 run_frame("R10 v6 esp", 18, 78, 0, 0);
    put_v6(18, 100, 6, 8);                 run_frame("R5 v6 short", 18, 78, 0, 0);
    put_v6(18, 20, 6, 8);                  run_frame("R12 v6 truncated", 18, 48, 0, 0);
    put_v4(14, 5, 40, 0, 0, 64, 6, 0);     run_frame("R9 rx error", 14, 60, 1, 0);
    put_v4(14, 5, 40, 0, 0, 0, 6, 1);      run_frame("R12 flags with code", 14, 60, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule